// File: doc/BRIEF.md
# Four-Channel Compare Timer with Watchdog

The block is a memory-mapped system timer. A 32-bit up-counter advances by one on every clock cycle in which the tick-enable input is high. Four compare registers are checked against the count that each tick produces. When a channel's compare value equals that count and the channel's interrupt is enabled, a sticky status bit sets and the channel's interrupt line goes high. The line stays high until software clears the bit by writing a one to it in the status register. Channel 3 also acts as a watchdog. When it matches while the watchdog is armed, the block issues a one-cycle system reset request and disarms the watchdog.

Software uses a simple single-cycle register bus with select, write strobe, byte address and write data. Read data is registered and appears on the cycle after the read is presented. The counter may be loaded at any time, and counting resumes from the loaded value.

Top module: `os_match_timer`

## Requirements
- R1: After synchronous reset the counter, all four compare registers, the status, the interrupt enable and the watchdog arm bit are zero, all four interrupt lines are low and the reset request is low.
- R2: The counter increments by one on each clock edge where tick_en is high and holds its value otherwise.
- R3: A bus write to the counter (offset 0x10) loads the written value. Counting continues from it. A load takes priority over a tick on the same edge.
- R4: The counter wraps from 0xFFFFFFFF to 0, and a compare value of 0 matches on that wrap.
- R5: A channel matches when the count reached by a tick equals its compare register. If the channel's enable bit is set, status bit n and irq_o[n] go high one cycle after that tick edge. If the enable bit is clear, neither changes.
- R6: Matches are evaluated only on ticks. A counter loaded to a compare value without ticking raises no status.
- R7: A write to the status register (offset 0x14) clears each bit that is written as one and is currently set, and deasserts that channel's interrupt line. Bits written as zero are unchanged, and writing ones to clear bits has no effect.
- R8: The interrupt-enable register (offset 0x1C) stores the low 12 bits of a write, and its upper 20 bits read as zero. Bits 0 to 3 gate channels 0 to 3.
- R9: A channel 3 match while watchdog bit 0 (offset 0x18) is set raises sys_reset_req for exactly one cycle and clears that bit, whether or not channel 3's interrupt is enabled. With the bit clear, no request is made.
- R10: Reads of undefined offsets return zero, and writes to them change no register.
- R11: Compare registers 0 to 3 are at offsets 0x00, 0x04, 0x08 and 0x0C. Read data for any register appears on bus_rdata in the cycle after the read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance enable, one tick per high cycle |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 4 | Per-channel interrupt lines |
| sys_reset_req | output | 1 | One-cycle system reset request from the watchdog |

## Verification
The compare function is exercised in several ways: single ticks that stop one count short of a compare value and then reach it, a load straight onto the compare value with no tick, a counter wrap onto a compare value of zero, and a match on a channel whose enable bit is clear. These separate a true tick-qualified equality test from one that is level-sensitive or ignores the enable. Status clears are tried with ones written over bits that are already clear and over bits that are set, which tells a masked clear from a plain overwrite. Channel 3 is matched three times: with the watchdog armed, with it disarmed, and armed with the channel's interrupt disabled. These cases separate the reset path from the interrupt path.

// File: rtl/omt_pkg.sv
package omt_pkg;
  localparam int unsigned OMT_ADDR_W = 8;
  localparam logic [OMT_ADDR_W-1:0] OFS_CMP0 = 8'h00;
  localparam logic [OMT_ADDR_W-1:0] OFS_CNT  = 8'h10;
  localparam logic [OMT_ADDR_W-1:0] OFS_STAT = 8'h14;
  localparam logic [OMT_ADDR_W-1:0] OFS_WDOG = 8'h18;
  localparam logic [OMT_ADDR_W-1:0] OFS_IEN  = 8'h1C;
  localparam int unsigned CMP_STRIDE = 4;
endpackage

// File: rtl/omt_counter.sv
module omt_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q,
  output logic         eval_q
);
  // eval_q marks the cycle in which cnt_q holds a value reached by a tick
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      eval_q <= 1'b0;
    end else begin
      eval_q <= tick_en & ~load;
      if (load)         cnt_q <= load_val;
      else if (tick_en) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/omt_compare_bank.sv
module omt_compare_bank #(
  parameter int unsigned W   = 32,
  parameter int unsigned NCH = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          wr_en,
  input  logic [W-1:0]            wdata,
  input  logic [W-1:0]            cnt,
  input  logic                    eval,
  output logic [NCH-1:0][W-1:0]   cmp_q,
  output logic [NCH-1:0]          hit
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)           cmp_q[g] <= '0;
      else if (wr_en[g]) cmp_q[g] <= wdata;
    end
    assign hit[g] = eval && (cnt == cmp_q[g]);
  end
endmodule

// File: rtl/omt_event_ctrl.sv
module omt_event_ctrl #(
  parameter int unsigned W       = 32,
  parameter int unsigned NCH     = 4,
  parameter int unsigned IE_W    = 12,
  parameter int unsigned WDOG_CH = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCH-1:0]  hit,
  input  logic            stat_wr,
  input  logic            ien_wr,
  input  logic            wdog_wr,
  input  logic [W-1:0]    wdata,
  output logic [NCH-1:0]  status_q,
  output logic [IE_W-1:0] ien_q,
  output logic            wdog_q,
  output logic            rst_req_q
);
  logic [NCH-1:0] set_v;
  logic [NCH-1:0] clr_v;

  always_comb begin
    set_v = hit & ien_q[NCH-1:0];
    clr_v = stat_wr ? (wdata[NCH-1:0] & status_q) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= '0;
      ien_q     <= '0;
      wdog_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_v) | set_v;
      if (ien_wr) ien_q <= wdata[IE_W-1:0];
      if (hit[WDOG_CH] && wdog_q) begin
        wdog_q    <= 1'b0;
        rst_req_q <= 1'b1;
      end else begin
        rst_req_q <= 1'b0;
        if (wdog_wr) wdog_q <= wdata[0];
      end
    end
  end
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NCH     = 4,
  parameter int unsigned IE_W    = 12,
  parameter int unsigned WDOG_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    irq_o,
  output logic              sys_reset_req
);
  import omt_pkg::*;

  logic                        wr_acc, rd_acc;
  logic                        cnt_wr, stat_wr, ien_wr, wdog_wr;
  logic [NCH-1:0]              cmp_wr;
  logic [NCH-1:0]              cmp_sel;
  logic [DATA_W-1:0]           cnt_q;
  logic                        eval_q;
  logic [NCH-1:0][DATA_W-1:0]  cmp_q;
  logic [NCH-1:0]              hit;
  logic [NCH-1:0]              status_q;
  logic [IE_W-1:0]             ien_q;
  logic                        wdog_q;
  logic [DATA_W-1:0]           rd_next;

  assign wr_acc = bus_sel & bus_wr;
  assign rd_acc = bus_sel & ~bus_wr;

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign cmp_sel[g] = (bus_addr == ADDR_W'(OFS_CMP0 + g * CMP_STRIDE));
    assign cmp_wr[g]  = wr_acc & cmp_sel[g];
  end

  assign cnt_wr  = wr_acc & (bus_addr == OFS_CNT);
  assign stat_wr = wr_acc & (bus_addr == OFS_STAT);
  assign ien_wr  = wr_acc & (bus_addr == OFS_IEN);
  assign wdog_wr = wr_acc & (bus_addr == OFS_WDOG);

  omt_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .load(cnt_wr),
    .load_val(bus_wdata), .cnt_q(cnt_q), .eval_q(eval_q)
  );

  omt_compare_bank #(.W(DATA_W), .NCH(NCH)) u_cmp (
    .clk(clk), .rst(rst), .wr_en(cmp_wr), .wdata(bus_wdata),
    .cnt(cnt_q), .eval(eval_q), .cmp_q(cmp_q), .hit(hit)
  );

  omt_event_ctrl #(.W(DATA_W), .NCH(NCH), .IE_W(IE_W), .WDOG_CH(WDOG_CH)) u_evt (
    .clk(clk), .rst(rst), .hit(hit), .stat_wr(stat_wr), .ien_wr(ien_wr),
    .wdog_wr(wdog_wr), .wdata(bus_wdata), .status_q(status_q),
    .ien_q(ien_q), .wdog_q(wdog_q), .rst_req_q(sys_reset_req)
  );

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NCH; i++) begin
      if (cmp_sel[i]) rd_next = cmp_q[i];
    end
    if (bus_addr == OFS_CNT)  rd_next = cnt_q;
    if (bus_addr == OFS_STAT) rd_next = DATA_W'(status_q);
    if (bus_addr == OFS_WDOG) rd_next = DATA_W'(wdog_q);
    if (bus_addr == OFS_IEN)  rd_next = DATA_W'(ien_q);
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_next;
  end

  assign irq_o = status_q;
endmodule

// File: rtl/omt_checker.sv
module omt_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NCH    = 4,
  parameter int unsigned IE_W   = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              cnt_wr,
  input logic [DATA_W-1:0] cnt_q,
  input logic [NCH-1:0]    hit,
  input logic [IE_W-1:0]   ien_q,
  input logic              stat_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NCH-1:0]    irq_o,
  input logic              sys_reset_req,
  input logic              wdog_q
);
  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !cnt_wr) |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !cnt_wr) |=> $stable(cnt_q));

  assert_reset_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |=> !sys_reset_req);

  assert_wdog_disarm_R9: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |-> !wdog_q);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_o[g]) |-> $past(hit[g] && ien_q[g]));

    assert_irq_clear_R7: assert property (@(posedge clk) disable iff (rst)
      (stat_wr && bus_wdata[g] && !hit[g]) |=> !irq_o[g]);
  end
endmodule

bind os_match_timer omt_checker #(.DATA_W(DATA_W), .NCH(NCH), .IE_W(IE_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .cnt_wr(cnt_wr), .cnt_q(cnt_q),
  .hit(hit), .ien_q(ien_q), .stat_wr(stat_wr), .bus_wdata(bus_wdata),
  .irq_o(irq_o), .sys_reset_req(sys_reset_req), .wdog_q(wdog_q)
);

// File: tb/os_match_timer_tb.sv
module os_match_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_o;
  logic        sys_reset_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [31:0] data; string tag; } exp_t;
  exp_t exp_q[$];
  logic rd_seen = 1'b0;

  always #5 clk = ~clk;

  os_match_timer u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .sys_reset_req(sys_reset_req)
  );

  // monitor: marks each read accepted at an edge, compares at the next negedge
  always @(posedge clk) rd_seen <= bus_sel && !bus_wr && !rst;
  always @(negedge clk) begin
    if (rd_seen) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (bus_rdata !== e.data) begin
        errors++;
        $display("FAIL %s: rdata actual %h expected %h", e.tag, bus_rdata, e.data);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk = 1'b0);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = tk;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.data = exp; e.tag = tag;
    exp_q.push_back(e);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic tick(input int n);
    tick_en = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 / R11: reset state and register map
    chk(irq_o, 0, "R1 irq");
    chk(sys_reset_req, 0, "R1 reset req");
    rd(8'h00, 0, "R1 cmp0"); rd(8'h04, 0, "R1 cmp1");
    rd(8'h08, 0, "R1 cmp2"); rd(8'h0C, 0, "R1 cmp3");
    rd(8'h10, 0, "R1 cnt");  rd(8'h14, 0, "R1 status");
    rd(8'h18, 0, "R1 wdog"); rd(8'h1C, 0, "R1 ien");
    wr(8'h04, 32'h11); wr(8'h08, 32'h22); wr(8'h0C, 32'h33);
    rd(8'h04, 32'h11, "R11 cmp1"); rd(8'h08, 32'h22, "R11 cmp2");
    rd(8'h0C, 32'h33, "R11 cmp3");
    // R3 / R2: load and count
    wr(8'h10, 100);
    rd(8'h10, 100, "R3 load");
    tick(5);
    rd(8'h10, 105, "R2 count");
    idle(2);
    rd(8'h10, 105, "R2 hold");
    // R5: enabled match
    wr(8'h00, 107); wr(8'h1C, 32'h1);
    tick(1); idle(1);
    chk(irq_o[0], 0, "R5 no match at 106");
    tick(1); idle(1);
    chk(irq_o[0], 1, "R5 irq0 on match");
    rd(8'h14, 32'h1, "R5 status0");
    // R5: disabled channel
    wr(8'h04, 110);
    tick(3); idle(1);
    chk(irq_o[1], 0, "R5 disabled ch1");
    rd(8'h14, 32'h1, "R5 status only ch0");
    // R7: masked clear
    wr(8'h14, 32'h6);
    rd(8'h14, 32'h1, "R7 clear of clear bits");
    chk(irq_o[0], 1, "R7 irq0 kept");
    wr(8'h14, 32'h1);
    rd(8'h14, 32'h0, "R7 cleared");
    chk(irq_o[0], 0, "R7 irq0 low");
    // R6: load onto compare value, no tick
    wr(8'h10, 107);
    idle(3);
    chk(irq_o[0], 0, "R6 no tick no match");
    tick(1); idle(1);
    chk(irq_o[0], 0, "R6 108 no match");
    // R3: load beats tick
    wr(8'h10, 32'h500, 1'b1);
    rd(8'h10, 32'h500, "R3 load over tick");
    // R4: wrap onto compare 0
    wr(8'h08, 0); wr(8'h1C, 32'h5);
    wr(8'h10, 32'hFFFF_FFFF);
    tick(1);
    rd(8'h10, 0, "R4 wrap");
    chk(irq_o[2], 1, "R4 match at wrap");
    rd(8'h14, 32'h4, "R4 status2");
    wr(8'h14, 32'h4);
    // R8: enable width
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, 32'h0000_0FFF, "R8 ien low 12");
    // R9: armed watchdog
    wr(8'h0C, 5); wr(8'h10, 3); wr(8'h18, 1);
    rd(8'h18, 1, "R9 armed");
    tick(2);
    @(negedge clk);
    chk(sys_reset_req, 1, "R9 request");
    chk(irq_o[3], 1, "R9 irq3");
    @(negedge clk);
    chk(sys_reset_req, 0, "R9 one cycle");
    rd(8'h18, 0, "R9 disarmed");
    // R9: disarmed, no request
    wr(8'h14, 32'h8);
    wr(8'h10, 4);
    tick(1); idle(1);
    chk(sys_reset_req, 0, "R9 no request when disarmed");
    chk(irq_o[3], 1, "R9 irq3 still");
    // R9: armed with ch3 interrupt off
    wr(8'h14, 32'h8); wr(8'h1C, 32'h7); wr(8'h18, 1);
    wr(8'h10, 4);
    tick(1); idle(1);
    chk(sys_reset_req, 1, "R9 request without ien3");
    chk(irq_o[3], 0, "R9 irq3 gated");
    idle(1);
    // R10: undefined offsets
    wr(8'h24, 32'hDEAD_BEEF); wr(8'h30, 32'h1234_5678); wr(8'h02, 32'hFFFF);
    rd(8'h24, 0, "R10 read 0x24");
    rd(8'h30, 0, "R10 read 0x30");
    rd(8'h00, 107, "R10 cmp0 untouched");
    rd(8'h1C, 32'h7, "R10 ien untouched");
    rd(8'h10, 5, "R10 cnt untouched");
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule